// File: doc/BRIEF.md
# Load/Store Ordering Violation Detector

This block watches the memory operations that an out-of-order core has issued but not yet retired. Each operation is allocated at issue, in program order, and carries a sequence number. Loads may execute before older stores whose address is not yet known. A load that executes records its address and marks itself as done. A store that executes later compares its address with every younger load that has already executed. A match means that the load may have returned a stale cached value and not the value the store produces. The block then reports the load so that the pipeline can restart from that load.

Only one violation is reported per cycle. When several younger loads match the same store, the oldest of them is reported, because restarting from it also covers the younger ones. Entries leave in program order as the core retires them. A flush removes the restart point and everything younger, so that the re-executed operations can be allocated again.

Top module: `mem_order_guard`

## Requirements
- R1: After reset the queue is empty. `alloc_stall` is 0 and `viol_valid` is 0. A store executed against an empty queue reports nothing.
- R2: `alloc_valid` writes one entry (kind and `alloc_seq`) at the young end of the queue. The queue holds up to 16 entries. `alloc_stall` is 1 exactly while 16 entries are held, and an allocation attempted while stalled is dropped.
- R3: `retire_valid` frees the oldest entry. A retire on an empty queue has no effect.
- R4: An executing load (`exec_is_store`=0) records its address and becomes "done". An executing store (`exec_is_store`=1) that is in the queue is compared with the done loads younger than itself. Addresses match when bits [31:3] are equal, which means the same 8-byte word. On a match, `viol_valid` is 1 in the cycle after the store's execute cycle, and `viol_seq` carries the seq of the matching load.
- R5: No violation is reported for a load in a different 8-byte word, a load not yet executed, or a load older than the store.
- R6: When several younger done loads match, `viol_seq` is the oldest one. Age uses 6-bit wrap-around order: a is younger than b when (a-b) mod 64 lies in 1..31.
- R7: `flush_valid` removes every entry whose seq equals `flush_seq` or is younger. Older entries survive. The freed slots can be allocated again.
- R8: In a flush cycle, alloc, execute and retire inputs are ignored, and no violation follows that cycle.
- R9: An execute whose seq is not held in the queue is ignored.
- R10: `viol_valid` is a single-cycle pulse. It rises only in the cycle after a store execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry for an issued operation |
| alloc_is_store | input | 1 | The allocated operation is a store |
| alloc_seq | input | 6 | Sequence number of the allocated operation |
| alloc_stall | output | 1 | Queue full; allocation refused |
| exec_valid | input | 1 | An operation executes with a known address |
| exec_is_store | input | 1 | The executing operation is a store |
| exec_seq | input | 6 | Sequence number of the executing operation |
| exec_addr | input | 32 | Byte address of the executing operation |
| retire_valid | input | 1 | Retire the oldest entry |
| flush_valid | input | 1 | Squash from the restart point |
| flush_seq | input | 6 | Restart point; this seq and all younger seqs are cleared |
| viol_valid | output | 1 | Ordering violation pulse |
| viol_seq | output | 6 | Seq of the oldest offending load |

## Verification
The assertions assume that allocation seqs are consecutive in program order, so that the live seqs span fewer than 32 values and wrap-around age order stays unambiguous. They also assume that each seq is held by at most one entry. The random stimulus keeps both conditions. It allocates from a single running counter that advances only on an accepted allocation. After a flush it rewinds the counter to the flush point, and it chooses that point among the seqs currently held. The stimulus also fills the queue, sends executes for seqs that are absent, and draws addresses from a small word pool so that matches are common.

// File: rtl/mem_order_guard.sv
module mem_order_guard #(
  parameter int DEPTH    = 16,
  parameter int SEQ_W    = 6,
  parameter int ADDR_W   = 32,
  parameter int WORD_OFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_stall,
  input  logic              exec_valid,
  input  logic              exec_is_store,
  input  logic [SEQ_W-1:0]  exec_seq,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              retire_valid,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq,
  output logic              viol_valid,
  output logic [SEQ_W-1:0]  viol_seq
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int WORD_W = ADDR_W - WORD_OFS;

  function automatic logic after(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  logic [DEPTH-1:0]  ent_vld, ent_st, ent_done;
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [WORD_W-1:0] ent_word [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  logic [WORD_W-1:0] exec_word;
  logic [DEPTH-1:0]  exec_hit, conflict, keep;
  logic [CNT_W-1:0]  keep_cnt;
  logic              found;
  logic [SEQ_W-1:0]  pick_seq;
  logic              alloc_fire, retire_fire, store_check;

  assign exec_word   = exec_addr[ADDR_W-1:WORD_OFS];
  assign alloc_stall = (count == CNT_W'(DEPTH));
  assign alloc_fire  = alloc_valid && !alloc_stall;
  assign retire_fire = retire_valid && (count != '0);
  assign store_check = exec_valid && exec_is_store && (|exec_hit);
  assign keep_cnt    = CNT_W'($countones(keep));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      exec_hit[i] = ent_vld[i] && (ent_seq[i] == exec_seq);
      conflict[i] = ent_vld[i] && !ent_st[i] && ent_done[i] &&
                    (ent_word[i] == exec_word) && after(ent_seq[i], exec_seq);
      keep[i]     = ent_vld[i] && after(flush_seq, ent_seq[i]);
    end
  end

  always_comb begin
    logic [PTR_W-1:0] idx;
    found    = 1'b0;
    pick_seq = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (!found && conflict[idx]) begin
        found    = 1'b1;
        pick_seq = ent_seq[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld    <= '0;
      ent_st     <= '0;
      ent_done   <= '0;
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      viol_valid <= 1'b0;
      viol_seq   <= '0;
    end else if (flush_valid) begin
      ent_vld    <= keep;
      tail       <= head + PTR_W'(keep_cnt);
      count      <= keep_cnt;
      viol_valid <= 1'b0;
    end else begin
      viol_valid <= store_check && found;
      if (store_check && found) viol_seq <= pick_seq;
      if (exec_valid) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (exec_hit[i]) begin
            ent_done[i] <= 1'b1;
            ent_word[i] <= exec_word;
          end
        end
      end
      if (retire_fire) begin
        ent_vld[head] <= 1'b0;
        head          <= head + 1'b1;
      end
      if (alloc_fire) begin
        ent_vld[tail]  <= 1'b1;
        ent_st[tail]   <= alloc_is_store;
        ent_done[tail] <= 1'b0;
        ent_seq[tail]  <= alloc_seq;
        tail           <= tail + 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
    end
  end
endmodule

module mem_order_guard_chk #(
  parameter int SEQ_W  = 6,
  parameter int ADDR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_stall,
  input logic             exec_valid,
  input logic             exec_is_store,
  input logic [SEQ_W-1:0] exec_seq,
  input logic             retire_valid,
  input logic             flush_valid,
  input logic             viol_valid,
  input logic [SEQ_W-1:0] viol_seq
);
  logic [SEQ_W-1:0] st_seq_q, gap;
  always_ff @(posedge clk) st_seq_q <= exec_seq;
  assign gap = viol_seq - st_seq_q;

  assert_viol_after_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(exec_valid && exec_is_store && !flush_valid));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> !viol_valid);

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall && !retire_valid && !flush_valid |=> alloc_stall);

  assert_retire_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall && retire_valid && !flush_valid |=> !alloc_stall);

  assert_load_younger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (gap != '0) && !gap[SEQ_W-1]);
endmodule

bind mem_order_guard mem_order_guard_chk #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_stall(alloc_stall), .exec_valid(exec_valid),
  .exec_is_store(exec_is_store), .exec_seq(exec_seq), .retire_valid(retire_valid),
  .flush_valid(flush_valid), .viol_valid(viol_valid), .viol_seq(viol_seq));

// File: tb/mem_order_guard_tb_top.sv
module mem_order_guard_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_is_store = 0, exec_valid = 0, exec_is_store = 0;
  logic retire_valid = 0, flush_valid = 0;
  logic [5:0] alloc_seq = '0, exec_seq = '0, flush_seq = '0;
  logic [31:0] exec_addr = '0;
  logic alloc_stall, viol_valid;
  logic [5:0] viol_seq;

  always #5 clk = ~clk;

  mem_order_guard dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_seq(alloc_seq), .alloc_stall(alloc_stall), .exec_valid(exec_valid),
    .exec_is_store(exec_is_store), .exec_seq(exec_seq), .exec_addr(exec_addr),
    .retire_valid(retire_valid), .flush_valid(flush_valid), .flush_seq(flush_seq),
    .viol_valid(viol_valid), .viol_seq(viol_seq));

  typedef struct { logic [5:0] seq; bit st; bit done; logic [28:0] word; } ent_t;
  ent_t mq[$];
  int checks = 0, fails = 0;
  string tag = "R1";
  logic [5:0] nseq = '0;

  function automatic bit older(input logic [5:0] a, input logic [5:0] b);
    logic [5:0] d;
    d = b - a;
    return (d != 0) && !d[5];
  endfunction

  task automatic chk(input string t, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic tick();
    bit exp_full, exp_v;
    logic [5:0] exp_s;
    int sidx;
    exp_full = (mq.size() == DEPTH);
    exp_v = 0; exp_s = '0;
    chk("R2", alloc_stall == exp_full, "alloc_stall", alloc_stall, exp_full);
    if (flush_valid) begin
      for (int k = mq.size() - 1; k >= 0; k--)
        if (!older(mq[k].seq, flush_seq)) mq.delete(k);
    end else begin
      sidx = -1;
      foreach (mq[k]) if (mq[k].seq == exec_seq) sidx = k;
      if (exec_valid && sidx >= 0) begin
        if (exec_is_store)
          foreach (mq[k])
            if (!exp_v && !mq[k].st && mq[k].done && mq[k].word == exec_addr[31:3] &&
                older(exec_seq, mq[k].seq)) begin
              exp_v = 1; exp_s = mq[k].seq;
            end
        mq[sidx].done = 1;
        mq[sidx].word = exec_addr[31:3];
      end
      if (retire_valid && mq.size() > 0) void'(mq.pop_front());
      if (alloc_valid && !exp_full) begin
        ent_t e;
        e.seq = alloc_seq; e.st = alloc_is_store; e.done = 0; e.word = '0;
        mq.push_back(e);
        nseq = alloc_seq + 1'b1;
      end
    end
    @(posedge clk); #1;
    chk(tag, viol_valid == exp_v, "viol_valid", viol_valid, exp_v);
    if (exp_v) chk(tag, viol_seq == exp_s, "viol_seq", viol_seq, exp_s);
    alloc_valid = 0; exec_valid = 0; retire_valid = 0; flush_valid = 0;
  endtask

  task automatic alloc(input bit st);
    alloc_valid = 1; alloc_is_store = st; alloc_seq = nseq; tick();
  endtask
  task automatic exe(input bit st, input logic [5:0] s, input logic [31:0] a);
    exec_valid = 1; exec_is_store = st; exec_seq = s; exec_addr = a; tick();
  endtask
  task automatic drain();
    while (mq.size() > 0) begin retire_valid = 1; tick(); end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [5:0] b;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", alloc_stall == 0 && viol_valid == 0, "reset outputs", {alloc_stall, viol_valid}, 0);
    tag = "R1"; exe(1, 6'd0, 32'h100);

    tag = "R4"; b = nseq;
    alloc(1); alloc(0);
    exe(0, b + 6'd1, 32'h100);
    exe(1, b, 32'h104);
    chk("R4", 1, "pulse", 0, 0);
    tag = "R10"; tick();
    drain();

    tag = "R5"; b = nseq;
    alloc(0); alloc(1); alloc(0); alloc(0);
    exe(0, b, 32'h200);
    exe(0, b + 6'd2, 32'h208);
    exe(1, b + 6'd1, 32'h200);
    drain();

    tag = "R9"; b = nseq;
    alloc(1); alloc(0);
    exe(0, b + 6'd1, 32'h300);
    exe(1, b + 6'd5, 32'h300);
    exe(0, b + 6'd7, 32'h300);
    drain();

    tag = "R6"; nseq = 6'd61; b = nseq;
    alloc(1); alloc(0); alloc(0); alloc(0);
    exe(0, 6'd0, 32'h400);
    exe(0, 6'd62, 32'h500);
    exe(0, 6'd63, 32'h407);
    exe(1, 6'd61, 32'h400);
    drain();

    tag = "R2";
    repeat (DEPTH) alloc(0);
    chk("R2", alloc_stall == 1, "stall when full", alloc_stall, 1);
    alloc(1);
    tag = "R3"; retire_valid = 1; tick();
    chk("R3", alloc_stall == 0, "stall after retire", alloc_stall, 0);
    drain();
    retire_valid = 1; tick();
    chk("R3", alloc_stall == 0, "retire on empty", alloc_stall, 0);

    tag = "R7"; b = nseq;
    alloc(1); alloc(0); alloc(0);
    exe(0, b + 6'd1, 32'h600); exe(0, b + 6'd2, 32'h600);
    tag = "R8";
    flush_valid = 1; flush_seq = b + 6'd1;
    exec_valid = 1; exec_is_store = 1; exec_seq = b; exec_addr = 32'h600;
    alloc_valid = 1; alloc_seq = b + 6'd3; retire_valid = 1;
    tick();
    nseq = b + 6'd1;
    tag = "R7";
    exe(1, b, 32'h600);
    alloc(0);
    exe(0, b + 6'd1, 32'h608);
    exe(1, b, 32'h60c);
    drain();

    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        flush_valid = 1;
        flush_seq = (mq.size() > 0) ? mq[$urandom_range(0, mq.size() - 1)].seq : nseq;
        tick();
        nseq = flush_seq;
      end else begin
        if ($urandom_range(0, 99) < 45) begin
          alloc_valid = 1; alloc_is_store = $urandom_range(0, 2) == 0; alloc_seq = nseq;
        end
        if ($urandom_range(0, 99) < 50) begin
          exec_valid = 1; exec_is_store = $urandom_range(0, 1);
          exec_addr = {26'h0, 3'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
          exec_seq = (mq.size() > 0 && $urandom_range(0, 9) != 0) ?
                     mq[$urandom_range(0, mq.size() - 1)].seq : nseq + 6'd20;
        end
        retire_valid = $urandom_range(0, 99) < 30;
        tick();
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule